// File: doc/BRIEF.md
# Guest External Interrupt Selector

This block sits beside a hart's hypervisor interrupt logic. Each virtual hart that can take interrupts directly from a device has one level-sensitive line into the block. The block samples those lines every cycle into a read-only pending register and keeps a software-written enable register beside it. A parameter, `NUM_GUEST`, sets how many virtual harts are served. The usable bit positions run from 1 up to `NUM_GUEST`. Bit 0 is never used, and `NUM_GUEST` may be zero.

The block drives two outputs, and they depend on the enable register in different ways. `vs_ext_o` is the pending bit of the virtual hart that is running now. That hart is named by a selector field which the hypervisor rewrites on each switch, and the enable register plays no part in this output. `guest_ext_o` is a hypervisor-level summary: it is high when any pending bit is also enabled. The hypervisor uses it to learn of interrupts aimed at virtual harts that are not running. Querying the interrupt controller and assigning devices to guests happen elsewhere.

Top module: `guest_irq_select`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the enable register, the pending register and the selector are 0, so both outputs are 0.
- R2: The pending read port returns the input lines sampled on the previous clock edge, masked to bits 1..`NUM_GUEST`; bit 0 and every bit above `NUM_GUEST` read 0.
- R3: A write to the enable register stores only bits 1..`NUM_GUEST` and is visible on the read port from the next cycle; bit 0 and bits above `NUM_GUEST` always read 0.
- R4: `guest_ext_o` is 1 exactly when the registered pending and enable values share a set bit.
- R5: When the selector holds a value k with 1 <= k <= `NUM_GUEST`, `vs_ext_o` equals pending bit k, whatever the enable register holds.
- R6: When the selector holds 0 or a value above `NUM_GUEST`, `vs_ext_o` is 0, even when input line 0 or a line above `NUM_GUEST` is high.
- R7: A selector write takes effect on the cycle after the write edge, so `vs_ext_o` follows the newly written value from that cycle on.
- R8: With `NUM_GUEST` = 0, both outputs and both read ports are constant 0 under any stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lines_i | input | REG_W | Level interrupt line per virtual hart; bit i serves hart i |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | REG_W | Enable register write data |
| en_rdata_o | output | REG_W | Enable register read data |
| pend_rdata_o | output | REG_W | Pending register read data |
| sel_we_i | input | 1 | Selector write strobe |
| sel_wdata_i | input | SEL_W | Index of the running virtual hart |
| vs_ext_o | output | 1 | External interrupt for the running virtual hart |
| guest_ext_o | output | 1 | Summary: some pending line is enabled |

## Verification
The hardest case to reach from the ports is a selector write that lands in the same cycle as a change in the pending lines. In that cycle the old selection and the new one point at pending bits with different values, so the check shows whether the output follows the new index on the very next cycle. The bench steps the selector through new indices on consecutive cycles and gives neighbouring lines opposite levels. A long random phase then mixes selector writes, enable writes and line changes. A second instance built with no usable bits takes the same stimulus, which covers the degenerate width.

// File: rtl/guest_irq_pkg.sv
package guest_irq_pkg;

    localparam int unsigned MAX_REG_W = 64;

    // Implemented-bit mask: positions 1..n set, everything else clear.
    function automatic logic [MAX_REG_W-1:0] guest_mask(int unsigned n);
        logic [MAX_REG_W-1:0] m;
        m = '0;
        for (int unsigned i = 1; i < MAX_REG_W; i++) begin
            if (i <= n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/guest_irq_regs.sv
module guest_irq_regs #(
    parameter int unsigned REG_W = 64,
    parameter int unsigned SEL_W = 6,
    parameter logic [REG_W-1:0] MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] lines_i,
    input  logic             en_we_i,
    input  logic [REG_W-1:0] en_wdata_i,
    input  logic             sel_we_i,
    input  logic [SEL_W-1:0] sel_wdata_i,
    output logic [REG_W-1:0] pend_q_o,
    output logic [REG_W-1:0] en_q_o,
    output logic [SEL_W-1:0] sel_q_o
);

    typedef struct packed {
        logic [REG_W-1:0] pend;
        logic [REG_W-1:0] en;
        logic [SEL_W-1:0] sel;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = lines_i & MASK;
        if (en_we_i)  st_d.en  = en_wdata_i & MASK;
        if (sel_we_i) st_d.sel = sel_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q_o = st_q.pend;
    assign en_q_o   = st_q.en;
    assign sel_q_o  = st_q.sel;

endmodule

// File: rtl/guest_irq_mux.sv
module guest_irq_mux #(
    parameter int unsigned REG_W     = 64,
    parameter int unsigned SEL_W     = 6,
    parameter int unsigned NUM_GUEST = 7
) (
    input  logic [REG_W-1:0] pend_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o
);

    localparam logic [SEL_W-1:0] TOP_IDX = SEL_W'(NUM_GUEST);

    logic             in_range;
    logic [REG_W-1:0] onehot;

    always_comb begin
        in_range = (sel_i != '0) && (sel_i <= TOP_IDX);
        onehot   = REG_W'(1) << sel_i;
        hit_o    = in_range & (|(pend_i & onehot));
    end

endmodule

// File: rtl/guest_irq_summary.sv
module guest_irq_summary #(
    parameter int unsigned REG_W = 64
) (
    input  logic [REG_W-1:0] pend_i,
    input  logic [REG_W-1:0] en_i,
    output logic             any_o
);

    always_comb any_o = |(pend_i & en_i);

endmodule

// File: rtl/guest_irq_select.sv
module guest_irq_select #(
    parameter int unsigned REG_W     = 64,
    parameter int unsigned NUM_GUEST = 7,
    parameter int unsigned SEL_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] lines_i,
    input  logic             en_we_i,
    input  logic [REG_W-1:0] en_wdata_i,
    output logic [REG_W-1:0] en_rdata_o,
    output logic [REG_W-1:0] pend_rdata_o,
    input  logic             sel_we_i,
    input  logic [SEL_W-1:0] sel_wdata_i,
    output logic             vs_ext_o,
    output logic             guest_ext_o
);

    localparam logic [REG_W-1:0] IMPL_MASK =
        REG_W'(guest_irq_pkg::guest_mask(NUM_GUEST));

    logic [REG_W-1:0] pend_q;
    logic [REG_W-1:0] en_q;
    logic [SEL_W-1:0] sel_q;

    guest_irq_regs #(
        .REG_W(REG_W), .SEL_W(SEL_W), .MASK(IMPL_MASK)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .lines_i     (lines_i),
        .en_we_i     (en_we_i),
        .en_wdata_i  (en_wdata_i),
        .sel_we_i    (sel_we_i),
        .sel_wdata_i (sel_wdata_i),
        .pend_q_o    (pend_q),
        .en_q_o      (en_q),
        .sel_q_o     (sel_q)
    );

    guest_irq_mux #(
        .REG_W(REG_W), .SEL_W(SEL_W), .NUM_GUEST(NUM_GUEST)
    ) u_mux (
        .pend_i (pend_q),
        .sel_i  (sel_q),
        .hit_o  (vs_ext_o)
    );

    guest_irq_summary #(.REG_W(REG_W)) u_sum (
        .pend_i (pend_q),
        .en_i   (en_q),
        .any_o  (guest_ext_o)
    );

    assign pend_rdata_o = pend_q;
    assign en_rdata_o   = en_q;

endmodule

// File: rtl/guest_irq_select_chk.sv
module guest_irq_select_chk #(
    parameter int unsigned REG_W     = 64,
    parameter int unsigned NUM_GUEST = 7,
    parameter int unsigned SEL_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] lines_i,
    input logic             sel_we_i,
    input logic [SEL_W-1:0] sel_wdata_i,
    input logic [REG_W-1:0] pend_rdata_o,
    input logic [REG_W-1:0] en_rdata_o,
    input logic             vs_ext_o,
    input logic             guest_ext_o
);

    localparam logic [REG_W-1:0] CHK_MASK =
        REG_W'(guest_irq_pkg::guest_mask(NUM_GUEST));
    localparam logic [SEL_W-1:0] CHK_TOP = SEL_W'(NUM_GUEST);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_rdata_o == '0 && pend_rdata_o == '0 && !vs_ext_o && !guest_ext_o));

    p_pend_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend_rdata_o == ($past(lines_i) & CHK_MASK)));

    p_en_unimpl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rdata_o & ~CHK_MASK) == '0);

    p_summary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        guest_ext_o == ((pend_rdata_o & en_rdata_o) != '0));

    p_sel_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_we_i) &&
         ($past(sel_wdata_i) == '0 || $past(sel_wdata_i) > CHK_TOP)) |-> !vs_ext_o);

    p_sel_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_we_i) &&
         $past(sel_wdata_i) != '0 && $past(sel_wdata_i) <= CHK_TOP)
        |-> (vs_ext_o == (((pend_rdata_o >> $past(sel_wdata_i)) & REG_W'(1)) != '0)));

    if (NUM_GUEST == 0) begin : g_zero
        p_zero_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !vs_ext_o && !guest_ext_o && pend_rdata_o == '0 && en_rdata_o == '0);
    end

endmodule

bind guest_irq_select guest_irq_select_chk #(
    .REG_W(REG_W), .NUM_GUEST(NUM_GUEST), .SEL_W(SEL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lines_i      (lines_i),
    .sel_we_i     (sel_we_i),
    .sel_wdata_i  (sel_wdata_i),
    .pend_rdata_o (pend_rdata_o),
    .en_rdata_o   (en_rdata_o),
    .vs_ext_o     (vs_ext_o),
    .guest_ext_o  (guest_ext_o)
);

// File: tb/test_guest_irq_select.sv
`timescale 1ns/1ps
module test_guest_irq_select;

    localparam int unsigned REG_W = 64;
    localparam int unsigned NUM_G = 7;
    localparam int unsigned SEL_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [REG_W-1:0] lines = '0;
    logic             en_we = 1'b0;
    logic [REG_W-1:0] en_wdata = '0;
    logic             sel_we = 1'b0;
    logic [SEL_W-1:0] sel_wdata = '0;

    logic [REG_W-1:0] en_rd, pend_rd, z_en_rd, z_pend_rd;
    logic             vs_ext, g_ext, z_vs_ext, z_g_ext;

    always #2 clk = ~clk;

    guest_irq_select #(.REG_W(REG_W), .NUM_GUEST(NUM_G), .SEL_W(SEL_W)) i_guest_irq_select (
        .clk(clk), .rst_n(rst_n), .lines_i(lines), .en_we_i(en_we), .en_wdata_i(en_wdata),
        .en_rdata_o(en_rd), .pend_rdata_o(pend_rd), .sel_we_i(sel_we), .sel_wdata_i(sel_wdata),
        .vs_ext_o(vs_ext), .guest_ext_o(g_ext));

    guest_irq_select #(.REG_W(REG_W), .NUM_GUEST(0), .SEL_W(SEL_W)) i_zero (
        .clk(clk), .rst_n(rst_n), .lines_i(lines), .en_we_i(en_we), .en_wdata_i(en_wdata),
        .en_rdata_o(z_en_rd), .pend_rdata_o(z_pend_rd), .sel_we_i(sel_we), .sel_wdata_i(sel_wdata),
        .vs_ext_o(z_vs_ext), .guest_ext_o(z_g_ext));

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // Behavioural reference state
    bit [63:0] m_mask;
    bit [63:0] m_pend, m_en;
    int        m_sel;
    bit        m_sel_new;

    initial begin
        m_mask = '0;
        for (int i = 1; i <= int'(NUM_G); i++) m_mask[i] = 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_en = '0; m_sel = 0; m_sel_new = 0;
        end else begin
            m_pend = lines & m_mask;
            if (en_we) m_en = en_wdata & m_mask;
            m_sel_new = sel_we;
            if (sel_we) m_sel = int'(sel_wdata);
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk("R1 en", en_rd, '0);
                chk("R1 pend", pend_rd, '0);
                chk("R1 vs", 64'(vs_ext), '0);
                chk("R1 sum", 64'(g_ext), '0);
            end else begin
                bit exp_vs;
                exp_vs = (m_sel >= 1 && m_sel <= int'(NUM_G)) ? m_pend[m_sel] : 1'b0;
                chk("R2 pend", pend_rd, m_pend);
                chk("R3 en", en_rd, m_en);
                chk("R4 sum", 64'(g_ext), 64'(|(m_pend & m_en)));
                if (m_sel_new)                              chk("R7 vs", 64'(vs_ext), 64'(exp_vs));
                else if (m_sel >= 1 && m_sel <= int'(NUM_G)) chk("R5 vs", 64'(vs_ext), 64'(exp_vs));
                else                                        chk("R6 vs", 64'(vs_ext), 64'(exp_vs));
            end
            chk("R8 zero", {z_en_rd | z_pend_rd} | 64'({z_vs_ext, z_g_ext}), '0);
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            en_we = 1'b0; sel_we = 1'b0;
        end
    endtask

    task automatic wr_en(logic [63:0] v);
        @(posedge clk); #1;
        en_we = 1'b1; en_wdata = v; sel_we = 1'b0;
    endtask

    task automatic wr_sel(int v);
        @(posedge clk); #1;
        sel_we = 1'b1; sel_wdata = SEL_W'(v); en_we = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        lines = '1;
        en_wdata = '1;
        step(3);
        rst_n = 1'b1;
        step(2);
        // R2: all lines high, only implemented bits visible
        lines = '1; step(2);
        // R3: write all ones to enable
        wr_en('1); step(2);
        // R4: pending and enable disjoint, then overlapping
        lines = 64'h8; wr_en(64'h20); step(2);
        wr_en(64'h8); step(2);
        // R5: enable cleared, selected bit still reaches vs
        wr_en('0); wr_sel(3); step(2);
        lines = 64'h0; step(2);
        // R6: selector 0 / beyond range while stray lines are high
        lines = '1; wr_sel(0); step(2);
        wr_sel(NUM_G + 1); step(2);
        wr_sel(63); step(2);
        // R7: back-to-back selector changes with alternating lines
        lines = 64'h54;
        for (int k = 1; k <= int'(NUM_G); k++) begin
            wr_sel(k);
            lines = ~lines;
        end
        step(2);
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            lines     = {$urandom, $urandom};
            en_we     = ($urandom % 4) == 0;
            en_wdata  = {$urandom, $urandom};
            sel_we    = ($urandom % 3) == 0;
            sel_wdata = SEL_W'($urandom % 12);
        end
        step(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule